// File: doc/BRIEF.md
# External Condition Branch Poller

This block resolves a branch that depends on a device outside the processor. When a branch-on-external operation is issued, the device number carried in the bottom four bits of the instruction word goes out on four select lines. A companion 16-to-1 selector picks that device's ready flag and returns it as a single condition line. After the select lines have been stable for a set number of cycles, the block samples the condition. It then reports whether the branch was taken, and gives the address execution continues at.

Software uses this to poll devices by number instead of taking an interrupt vector. A service routine runs through a list of these operations, one per device. The first device that reports ready sends control to its own handler. Fetching instructions and the rest of the program counter datapath are outside this block. The caller supplies the current address, the instruction length and the branch target, and takes the result from `next_addr`.

Top module: `ext_branch_poller`

## Requirements
- R1: During and immediately after synchronous reset, `sel_out`, `busy`, `done` and `taken` are 0 and `next_addr` is 0.
- R2: When `op_valid` is high on a clock edge while `busy` is low, the operation is accepted. From the next cycle, bit i of `sel_out` is high exactly when bit i of `op_word[3:0]` is set. `sel_out` holds that value unchanged for `SETTLE_CYC` cycles.
- R3: Whenever no operation is in progress (`busy` low), `sel_out` is 0.
- R4: The condition is sampled on the edge that ends the `SETTLE_CYC`-th cycle of select drive. On that edge `busy` drops, `sel_out` returns to 0, and `done` goes high for exactly one cycle.
- R5: If the sampled condition is 1, `taken` is 1 and `next_addr` equals the 16-bit `op_target` that was captured at acceptance.
- R6: If the sampled condition is 0, `taken` is 0 and `next_addr` equals `op_pc + op_len` (modulo 2^16), using the values captured at acceptance. `op_len` is the instruction length in words, from 1 to 3.
- R7: `cond_line` always equals `dev_ready[sel_out]`, the flag of the device currently selected.
- R8: Changes to `op_valid` and the op fields while `busy` is high have no effect. Values of `dev_ready` other than those present at the sampling edge do not affect the result.
- R9: `taken` and `next_addr` keep their values until the next `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue a branch-on-external operation |
| op_word | input | 16 | Instruction word; bits [3:0] are the device number |
| op_pc | input | 16 | Address of the issuing instruction |
| op_target | input | 16 | Branch target address |
| op_len | input | 2 | Instruction length in words (1 to 3) |
| dev_ready | input | 16 | Ready flags of the sixteen devices |
| cond_line | output | 1 | Selected device flag from the 16-to-1 selector |
| sel_out | output | 4 | Device select lines |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| taken | output | 1 | Branch taken |
| next_addr | output | 16 | Address where execution continues |

## Verification
A corrupted select register shows up at once on `sel_out` and `cond_line`, in the cycle after acceptance. A wrong settle count shifts `done` earlier or later by at least a cycle. It also lets a `dev_ready` value that should have been ignored decide `taken`. A stale or wrongly captured address shows up in `next_addr` on the `done` cycle. Random device numbers, lengths and ready patterns are mixed with directed cases: device 0, device 15, and an address that wraps.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRIVE = 1'b1
  } ebp_state_e;
endpackage

// File: rtl/ebp_devmux.sv
// Routes one of N_DEV ready flags onto the single condition line.
module ebp_devmux #(
  parameter int N_DEV = 16,
  localparam int SEL_W = $clog2(N_DEV)
) (
  input  logic [N_DEV-1:0] flags,
  input  logic [SEL_W-1:0] sel,
  output logic             cond
);
  logic [N_DEV-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_DEV; gi++) begin : g_lane
      assign hit[gi] = flags[gi] & (sel == SEL_W'(gi));
    end
  endgenerate

  assign cond = |hit;
endmodule

// File: rtl/ebp_nextpc.sv
// Fall-through address: current address plus instruction length.
module ebp_nextpc #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] fall
);
  assign fall = pc + ADDR_W'(len);
endmodule

// File: rtl/ebp_ctrl.sv
// Sequencer: drives the selects, waits, samples the condition, resolves the address.
module ebp_ctrl
  import ebp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SEL_W      = 4,
  parameter int SETTLE_CYC = 2,
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SEL_W-1:0]  dev_num,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] fall,
  input  logic              cond,
  output logic [SEL_W-1:0]  sel_out,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] next_addr
);
  ebp_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sel_out   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      taken     <= 1'b0;
      next_addr <= '0;
      tgt_q     <= '0;
      fall_q    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_DRIVE;
            sel_out <= dev_num;
            busy    <= 1'b1;
            cnt     <= CNT_W'(SETTLE_CYC - 1);
            tgt_q   <= target;
            fall_q  <= fall;
          end
        end
        ST_DRIVE: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            sel_out   <= '0;
            busy      <= 1'b0;
            done      <= 1'b1;
            taken     <= cond;
            next_addr <= cond ? tgt_q : fall_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r3_idle_sel_zero: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sel_out == '0));

  a_r2_sel_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sel_out));

  a_r4_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(taken) && $stable(next_addr)));
endmodule

// File: rtl/ext_branch_poller.sv
module ext_branch_poller #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 16,
  parameter int LEN_W      = 2,
  parameter int N_DEV      = 16,
  parameter int SETTLE_CYC = 2,
  localparam int SEL_W = $clog2(N_DEV)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] op_word,
  input  logic [ADDR_W-1:0] op_pc,
  input  logic [ADDR_W-1:0] op_target,
  input  logic [LEN_W-1:0]  op_len,
  input  logic [N_DEV-1:0]  dev_ready,
  output logic              cond_line,
  output logic [SEL_W-1:0]  sel_out,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] fall_w;

  ebp_nextpc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_nextpc (
    .pc  (op_pc),
    .len (op_len),
    .fall(fall_w)
  );

  ebp_devmux #(.N_DEV(N_DEV)) u_mux (
    .flags(dev_ready),
    .sel  (sel_out),
    .cond (cond_line)
  );

  ebp_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (op_valid),
    .dev_num  (op_word[SEL_W-1:0]),
    .target   (op_target),
    .fall     (fall_w),
    .cond     (cond_line),
    .sel_out  (sel_out),
    .busy     (busy),
    .done     (done),
    .taken    (taken),
    .next_addr(next_addr)
  );
endmodule

// File: tb/tb_ext_branch_poller.sv
module tb_ext_branch_poller;
  localparam int SETTLE = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [15:0] op_word, op_pc, op_target;
  logic [1:0]  op_len;
  logic [15:0] dev_ready;
  logic        cond_line, busy, done, taken;
  logic [3:0]  sel_out;
  logic [15:0] next_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic        last_taken;
  logic [15:0] last_next;

  ext_branch_poller #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
    .op_pc(op_pc), .op_target(op_target), .op_len(op_len),
    .dev_ready(dev_ready), .cond_line(cond_line), .sel_out(sel_out),
    .busy(busy), .done(done), .taken(taken), .next_addr(next_addr)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] exp_next(logic tk, logic [15:0] tgt,
                                           logic [15:0] pc, logic [1:0] len);
    return tk ? tgt : pc + 16'(len);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One operation: accept, noise on dev_ready and op fields while busy,
  // final ready pattern present at the sampling edge.
  task automatic run_op(logic [3:0] dev, logic [15:0] pc, logic [15:0] tgt,
                        logic [1:0] len, logic [15:0] rdy_final);
    logic tk;
    @(negedge clk);
    op_valid  = 1'b1;
    op_word   = {12'($urandom), dev};
    op_pc     = pc;
    op_target = tgt;
    op_len    = len;
    dev_ready = 16'($urandom);
    for (int k = 0; k < SETTLE; k++) begin
      @(negedge clk);
      chk("R2 sel", 32'(sel_out), 32'(dev));
      chk("R4 busy", 32'(busy), 32'd1);
      chk("R4 done low", 32'(done), 32'd0);
      chk("R7 mux", 32'(cond_line), 32'(dev_ready[dev]));
      chk("R9 hold taken", 32'(taken), 32'(last_taken));
      // R8: garbage ops while busy
      op_valid  = (k < SETTLE - 1);
      op_word   = 16'($urandom);
      op_pc     = 16'($urandom);
      op_target = 16'($urandom);
      op_len    = 2'($urandom);
      dev_ready = (k == SETTLE - 1) ? rdy_final : 16'($urandom);
    end
    @(negedge clk);
    tk = rdy_final[dev];
    chk("R4 done", 32'(done), 32'd1);
    chk("R4 busy drop", 32'(busy), 32'd0);
    chk("R3 sel zero", 32'(sel_out), 32'd0);
    chk(tk ? "R5 taken" : "R6 not taken", 32'(taken), 32'(tk));
    chk(tk ? "R5 target" : "R6 fallthru", 32'(next_addr),
        32'(exp_next(tk, tgt, pc, len)));
    last_taken = tk;
    last_next  = exp_next(tk, tgt, pc, len);
    op_valid  = 1'b0;
    dev_ready = 16'hFFFF;
    @(negedge clk);
    chk("R4 done pulse", 32'(done), 32'd0);
    chk("R3 idle sel", 32'(sel_out), 32'd0);
    chk("R7 idle mux", 32'(cond_line), 32'(dev_ready[0]));
    chk("R9 hold next", 32'(next_addr), 32'(last_next));
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; op_valid = 1'b0; op_word = '0; op_pc = '0;
    op_target = '0; op_len = 2'd1; dev_ready = '0;
    last_taken = 1'b0; last_next = '0;
    repeat (3) @(negedge clk);
    chk("R1 sel", 32'(sel_out), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 taken", 32'(taken), 32'd0);
    chk("R1 next", 32'(next_addr), 32'd0);
    rst = 1'b0;
    // R3/R8: idle with all devices ready
    dev_ready = 16'hFFFF;
    repeat (3) begin
      @(negedge clk);
      chk("R3 idle sel", 32'(sel_out), 32'd0);
      chk("R8 idle done", 32'(done), 32'd0);
    end
    // directed corners
    run_op(4'd0,  16'h1000, 16'h2000, 2'd1, 16'h0001);
    run_op(4'd15, 16'h1234, 16'hBEEF, 2'd2, 16'h7FFF);
    run_op(4'd15, 16'h1234, 16'hBEEF, 2'd3, 16'h8000);
    run_op(4'd9,  16'hFFFF, 16'h0042, 2'd2, 16'hFDFF);
    run_op(4'd5,  16'hFFFE, 16'hABCD, 2'd3, 16'h0020);
    // random
    for (int i = 0; i < 60; i++)
      run_op(4'($urandom), 16'($urandom), 16'($urandom),
             2'($urandom_range(3, 1)), 16'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule